// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Sequencer

This block watches the calendar time kept by a real-time clock core and compares it with a second, full-date wake/shutdown alarm. The compare covers seconds, minutes, hours, day, month and year, all in BCD. On a match it raises an alarm status flag and can interrupt the host. If the host has handed control of the power-enable line to the alarm logic, the same event also drops the power-enable output. An external power-management chip reads that line and shuts its regulators down.

The match is evaluated only on the cycle in which the clock core updates its seconds count, so one alarm time fires at most once. Firmware loads the alarm at least two seconds ahead of the current time, so the setting is in place before the next seconds update. Once the power-enable line has dropped, it stays low until the block is reset.

Top module: `pwr_alarm_seq`

## Requirements
- R1: After reset, `pwr_en_o` is 1, `alm_stat_o` is 0 and `alm_irq_o` is 0.
- R2: The time and alarm vectors hold field i in bits [8i+7:8i], with field 0 = seconds, 1 = minutes, 2 = hours, 3 = day, 4 = month and 5 = year. When `sec_tick_i` is 1 and `now_i` equals `alarm_i` at a clock edge, `alm_stat_o` reads 1 after that edge.
- R3: While `sec_tick_i` is 0, equality of `now_i` and `alarm_i` never sets `alm_stat_o` and never changes `pwr_en_o`.
- R4: A difference in any single field (seconds, minutes, hours, day, month or year) at a tick prevents the event.
- R5: When `pwr_arm_i` is 1 at the edge where the event is detected, `pwr_en_o` falls to 0 after that same edge.
- R6: When `pwr_arm_i` is 0 at the event, `alm_stat_o` is still set but `pwr_en_o` stays 1.
- R7: `alm_irq_o` is 1 exactly when `alm_stat_o` is 1 and `alm_irq_en_i` is 1, with no added latency.
- R8: A one-cycle `alm_clr_i` pulse clears `alm_stat_o` after the edge. An event on the same edge wins over the clear.
- R9: Once `pwr_en_o` is 0, it stays 0 through clears, disarming and further ticks until reset.
- R10: Setting `pwr_arm_i` after an event has already occurred, with no new matching tick, leaves `pwr_en_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick_i | input | 1 | One-cycle strobe: the seconds field of `now_i` was just updated |
| now_i | input | 48 | Current BCD time, six 8-bit fields |
| alarm_i | input | 48 | Shutdown alarm BCD time, same layout |
| pwr_arm_i | input | 1 | Gives the alarm logic control of the power-enable line |
| alm_irq_en_i | input | 1 | Interrupt enable for the alarm status |
| alm_clr_i | input | 1 | Clears the alarm status |
| pwr_en_o | output | 1 | Power-enable to the external power controller, 1 = on |
| alm_stat_o | output | 1 | Alarm event status flag |
| alm_irq_o | output | 1 | Alarm interrupt request |

## Verification
The case that is hardest to reach from the ports is a clear and a new event landing on the same edge. The status is already set when this happens, so a design that let the clear win would look correct unless a clear pulse and a matching tick are driven in the very same cycle. The bench first leaves the status set with an unarmed match. It then drives both strobes together and checks the flag, and issues a lone clear afterwards to confirm the clear still works. Single-field mismatches are walked one field at a time, flipping the low bit of each field in turn.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam int TIME_W     = FIELD_W * NUM_FIELDS;
endpackage

// File: rtl/pwr_time_cmp.sv
module pwr_time_cmp #(
  parameter int FIELD_W    = pwr_seq_pkg::FIELD_W,
  parameter int NUM_FIELDS = pwr_seq_pkg::NUM_FIELDS,
  localparam int TIME_W    = FIELD_W * NUM_FIELDS
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] alarm_i,
  output logic              match_o
);
  logic [NUM_FIELDS-1:0] field_eq;

  // One equality slice per calendar field.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign field_eq[f] = (now_i[f*FIELD_W +: FIELD_W] == alarm_i[f*FIELD_W +: FIELD_W]);
  end

  assign match_o = &field_eq;
endmodule

// File: rtl/pwr_alm_status.sv
module pwr_alm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_i)   stat_d = 1'b0;
    if (event_i) stat_d = 1'b1;   // event has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> stat_q);                                   // R2
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !event_i) |=> !stat_q);                      // R8
endmodule

// File: rtl/pwr_en_latch.sv
module pwr_en_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic arm_i,
  output logic pwr_en_o
);
  logic pwr_q, pwr_d;
  logic drop_en;

  assign drop_en = event_i & arm_i;

  always_comb begin
    pwr_d = pwr_q;
    if (drop_en) pwr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= 1'b1;
    else        pwr_q <= pwr_d;
  end

  assign pwr_en_o = pwr_q;

  AST_PWR_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> !pwr_q);                                    // R9
  AST_UNARMED_KEEPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q && !arm_i) |=> pwr_q);                          // R6
endmodule

// File: rtl/pwr_alarm_seq.sv
module pwr_alarm_seq #(
  parameter int FIELD_W    = pwr_seq_pkg::FIELD_W,
  parameter int NUM_FIELDS = pwr_seq_pkg::NUM_FIELDS,
  localparam int TIME_W    = FIELD_W * NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] alarm_i,
  input  logic              pwr_arm_i,
  input  logic              alm_irq_en_i,
  input  logic              alm_clr_i,
  output logic              pwr_en_o,
  output logic              alm_stat_o,
  output logic              alm_irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       match;
  logic       alm_event;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pwr_time_cmp #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_cmp (
    .now_i   (now_i),
    .alarm_i (alarm_i),
    .match_o (match)
  );

  // Compare only on the seconds-update cycle.
  assign alm_event = sec_tick_i & match;

  pwr_alm_status u_stat (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .event_i (alm_event),
    .clr_i   (alm_clr_i),
    .stat_o  (alm_stat_o)
  );

  pwr_en_latch u_pwr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .event_i  (alm_event),
    .arm_i    (pwr_arm_i),
    .pwr_en_o (pwr_en_o)
  );

  assign alm_irq_o = alm_stat_o & alm_irq_en_i;

  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(alm_stat_o) |-> $past(sec_tick_i));              // R3
  AST_PWR_FALL_WITH_STAT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(pwr_en_o) |-> alm_stat_o);                       // R5
endmodule

// File: tb/pwr_alarm_seq_test.sv
`timescale 1ns/1ps
module pwr_alarm_seq_test;
  localparam int TW = 48;
  localparam logic [TW-1:0] ALM = 48'h25_06_15_23_59_58;

  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick_i, pwr_arm_i, alm_irq_en_i, alm_clr_i;
  logic [TW-1:0] now_i, alarm_i;
  logic pwr_en_o, alm_stat_o, alm_irq_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_alarm_seq uut (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick_i), .now_i(now_i),
    .alarm_i(alarm_i), .pwr_arm_i(pwr_arm_i), .alm_irq_en_i(alm_irq_en_i),
    .alm_clr_i(alm_clr_i), .pwr_en_o(pwr_en_o), .alm_stat_o(alm_stat_o),
    .alm_irq_o(alm_irq_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sec_tick_i = 0; pwr_arm_i = 0; alm_irq_en_i = 0; alm_clr_i = 0;
    now_i = '0; alarm_i = ALM;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drives one tick cycle with the given time, returns at the following negedge.
  task automatic tick_at(input logic [TW-1:0] t);
    now_i = t; sec_tick_i = 1'b1;
    @(negedge clk);
    sec_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(pwr_en_o, 1'b1, "R1 pwr_en after reset");
    chk(alm_stat_o, 1'b0, "R1 status after reset");
    chk(alm_irq_o, 1'b0, "R1 irq after reset");
  endtask

  task automatic t_armed_match();
    do_reset();
    pwr_arm_i = 1; alm_irq_en_i = 1;
    tick_at(ALM);
    chk(alm_stat_o, 1'b1, "R2 status on match");
    chk(pwr_en_o, 1'b0, "R5 pwr_en drops when armed");
    chk(alm_irq_o, 1'b1, "R7 irq with enable");
    pwr_arm_i = 0; alm_clr_i = 1;
    @(negedge clk);
    alm_clr_i = 0;
    chk(alm_stat_o, 1'b0, "R8 clear");
    chk(pwr_en_o, 1'b0, "R9 pwr_en after clear");
    tick_at(ALM + 48'h1);
    repeat (4) @(negedge clk);
    chk(pwr_en_o, 1'b0, "R9 pwr_en held low");
    do_reset();
    chk(pwr_en_o, 1'b1, "R1 pwr_en restored by reset");
  endtask

  task automatic t_no_tick();
    do_reset();
    pwr_arm_i = 1; now_i = ALM;
    repeat (5) @(negedge clk);
    chk(alm_stat_o, 1'b0, "R3 no status without tick");
    chk(pwr_en_o, 1'b1, "R3 pwr_en without tick");
  endtask

  task automatic t_field_miss();
    do_reset();
    pwr_arm_i = 1;
    for (int f = 0; f < 6; f++) begin
      tick_at(ALM ^ (48'h1 << (8*f)));
      chk(alm_stat_o, 1'b0, $sformatf("R4 field %0d mismatch status", f));
      chk(pwr_en_o, 1'b1, $sformatf("R4 field %0d mismatch pwr_en", f));
    end
  endtask

  task automatic t_unarmed_and_priority();
    do_reset();
    tick_at(ALM);
    chk(alm_stat_o, 1'b1, "R6 status set unarmed");
    chk(pwr_en_o, 1'b1, "R6 pwr_en kept unarmed");
    chk(alm_irq_o, 1'b0, "R7 irq masked");
    alm_irq_en_i = 1; #1;
    chk(alm_irq_o, 1'b1, "R7 irq follows enable");
    alm_irq_en_i = 0; #1;
    chk(alm_irq_o, 1'b0, "R7 irq drops with enable");
    @(negedge clk);
    alm_clr_i = 1;
    tick_at(ALM);
    alm_clr_i = 0;
    chk(alm_stat_o, 1'b1, "R8 event wins over clear");
    alm_clr_i = 1;
    @(negedge clk);
    alm_clr_i = 0;
    chk(alm_stat_o, 1'b0, "R8 lone clear");
    pwr_arm_i = 1;
    repeat (3) @(negedge clk);
    chk(pwr_en_o, 1'b1, "R10 late arm no drop");
    tick_at(ALM + 48'h1);
    chk(pwr_en_o, 1'b1, "R10 late arm mismatched tick");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_armed_match();
    t_no_tick();
    t_field_miss();
    t_unarmed_and_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule